// File: doc/BRIEF.md
# Streaming Audio Sample Counter with Compare Interrupt

This block counts the output samples of a streaming audio path and raises an interrupt when the count reaches a programmed value. Software configures it through four word-wide registers: a control word, a volume word, the live sample counter and a compare word. While the run bit is set, the counter advances by one on each pulse of the sample tick that the rate bit selects. One tick input arrives at the 32 kHz rate and the other at the 48 kHz rate. When an increment brings the counter to the compare value, a sticky status bit is set. Software can turn this off with a match-disable bit. The interrupt output is the status gated by a mask bit.

A run-control state machine holds the enable. It has two states. `ST_STOP` is entered from reset and also by a control write with the run bit at 0. `ST_RUN` is entered by a control write with the run bit at 1. There are two transitions: STOP->RUN (start) and RUN->STOP (halt). The control word also holds a counter-clear bit, which clears itself after use. It also holds a rate bit for the DMA side, with the opposite encoding to the streaming rate bit, and this bit is decoded onto an output pin.

Register access is a single-cycle write strobe with a 2-bit address. Reads are combinational from the address. Clock generation, sample data and volume scaling are handled by neighbouring blocks.

Top module: `ssc_stream_counter`

## Requirements
- R1: After reset, all four registers read 0, `irq` is 0, `dma_rate_48k` is 1, and the state machine is in `ST_STOP`.
- R2: In `ST_RUN` (control bit 0 = 1), the counter increases by exactly 1 at each clock edge where the selected tick is high. In `ST_STOP`, the counter holds its value.
- R3: Control bit 1 chooses the tick. At 0 the counter follows `tick_32k`; at 1 it follows `tick_48k`. The unselected tick has no effect.
- R4: The counter wraps from 0xFFFFFFFF to 0 on an increment.
- R5: With control bit 4 = 0, the increment that makes the counter equal the compare register sets status bit 3 at that same edge. The status stays set while further counting occurs. Only increments perform this check.
- R6: With control bit 4 = 1, a match leaves status bit 3 unchanged.
- R7: A control write with bit 3 = 1 clears the status, and a write with bit 3 = 0 leaves it unchanged. A match in the same cycle as the clearing write wins, so the status is set.
- R8: `irq` equals status bit 3 AND mask bit 2.
- R9: A control write with bit 5 = 1 makes the counter 0 at that edge. This overrides a tick or a counter write, and it does not set the status, even when the compare value is 0. Bit 5 always reads 0.
- R10: `dma_rate_48k` is 1 when control bit 6 is 0 (48 kHz) and 0 when bit 6 is 1 (32 kHz).
- R11: The register map is: address 0 control, 1 volume (32-bit storage), 2 counter (a write loads it and takes priority over a tick), 3 compare.
- R12: Control bits 31..7 read as 0 whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| tick_32k | input | 1 | One-cycle pulse per 32 kHz sample |
| tick_48k | input | 1 | One-cycle pulse per 48 kHz sample |
| irq | output | 1 | Masked interrupt |
| dma_rate_48k | output | 1 | Decoded DMA-side rate |

## Verification
The counter is driven with both tick inputs pulsing under each rate setting. This shows whether the selection follows bit 1 or leaks the other tick, and whether a stopped counter really holds. Compare scenarios approach the compare value from below, continue counting past it, cross it at the 32-bit wrap, and reach it with match disabled. These separate a sticky, once-per-crossing status from a level match or a match that ignores the disable bit. Collision cycles put a clear, load or status write in the same edge as a tick or a match, and each one exposes a wrong priority order. A behavioural model is compared against `rdata`, `irq` and `dma_rate_48k` on every clock.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_VOL  = 2'd1,
        A_CNT  = 2'd2,
        A_CMP  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam int B_RUN   = 0;
    localparam int B_SRATE = 1;
    localparam int B_MASK  = 2;
    localparam int B_STAT  = 3;
    localparam int B_MOFF  = 4;
    localparam int B_CLR   = 5;
    localparam int B_DRATE = 6;
    localparam int CTRL_W  = 7;

endpackage

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
    import ssc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              match_hit,
    output logic              run,
    output logic              srate,
    output logic              mask,
    output logic              moff,
    output logic              drate,
    output logic              status,
    output logic              clr_pulse,
    output logic [DATA_W-1:0] ctrl_rd
);

    localparam int PAD_W = DATA_W - CTRL_W;

    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (ctrl_wr && ctrl_wdata[B_RUN])  state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr && !ctrl_wdata[B_RUN]) state_d = ST_STOP;
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srate <= 1'b0;
            mask  <= 1'b0;
            moff  <= 1'b0;
            drate <= 1'b0;
        end else if (ctrl_wr) begin
            srate <= ctrl_wdata[B_SRATE];
            mask  <= ctrl_wdata[B_MASK];
            moff  <= ctrl_wdata[B_MOFF];
            drate <= ctrl_wdata[B_DRATE];
        end
    end

    logic stat_set, stat_clr;
    assign stat_set = match_hit && !moff;
    assign stat_clr = ctrl_wr && ctrl_wdata[B_STAT];

    always_ff @(posedge clk) begin
        if (!rst_n)        status <= 1'b0;
        else if (stat_set) status <= 1'b1;
        else if (stat_clr) status <= 1'b0;
    end

    assign clr_pulse = ctrl_wr && ctrl_wdata[B_CLR];

    assign ctrl_rd = {{PAD_W{1'b0}}, drate, 1'b0, moff, status, mask, srate, run};

endmodule

// File: rtl/ssc_tick_sel.sv
module ssc_tick_sel (
    input  logic tick_32k,
    input  logic tick_48k,
    input  logic srate,
    input  logic run,
    output logic step
);

    always_comb begin
        unique case (srate)
            1'b1:    step = run && tick_48k;
            default: step = run && tick_32k;
        endcase
    end

endmodule

// File: rtl/ssc_counter.sv
module ssc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         hit,
    output logic         inc
);

    logic [W-1:0] cnt_next;

    assign cnt_next = cnt + W'(1);
    assign inc      = step && !clr && !ld;
    assign hit      = inc && (cnt_next == cmp);

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (inc) cnt <= cnt_next;
    end

endmodule

// File: rtl/ssc_regfile.sv
module ssc_regfile
    import ssc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ctrl_rd,
    input  logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] cmp,
    output logic [DATA_W-1:0] rdata
);

    localparam int NWORD = 2;
    localparam reg_addr_e WADDR [NWORD] = '{A_VOL, A_CMP};

    logic [DATA_W-1:0] word_q [NWORD];

    for (genvar i = 0; i < NWORD; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                                   word_q[i] <= '0;
            else if (wr_en && (addr == 2'(WADDR[i])))     word_q[i] <= wdata;
        end
    end

    assign cmp = word_q[1];

    always_comb begin
        unique case (reg_addr_e'(addr))
            A_CTRL:  rdata = ctrl_rd;
            A_VOL:   rdata = word_q[0];
            A_CNT:   rdata = cnt;
            A_CMP:   rdata = word_q[1];
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/ssc_stream_counter.sv
module ssc_stream_counter
    import ssc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_32k,
    input  logic              tick_48k,
    output logic              irq,
    output logic              dma_rate_48k
);

    logic              wr_ctrl, wr_cnt;
    logic              run, srate, mask, moff, drate, status, clr_pulse;
    logic              step, hit, inc;
    logic [DATA_W-1:0] ctrl_rd, cnt_q, cmp_q;

    assign wr_ctrl = wr_en && (addr == 2'(A_CTRL));
    assign wr_cnt  = wr_en && (addr == 2'(A_CNT));

    ssc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_ctrl),
        .ctrl_wdata (wdata[CTRL_W-1:0]),
        .match_hit  (hit),
        .run        (run),
        .srate      (srate),
        .mask       (mask),
        .moff       (moff),
        .drate      (drate),
        .status     (status),
        .clr_pulse  (clr_pulse),
        .ctrl_rd    (ctrl_rd)
    );

    ssc_tick_sel u_tick (
        .tick_32k (tick_32k),
        .tick_48k (tick_48k),
        .srate    (srate),
        .run      (run),
        .step     (step)
    );

    ssc_counter #(.W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .clr    (clr_pulse),
        .ld     (wr_cnt),
        .ld_val (wdata),
        .cmp    (cmp_q),
        .cnt    (cnt_q),
        .hit    (hit),
        .inc    (inc)
    );

    ssc_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .ctrl_rd (ctrl_rd),
        .cnt     (cnt_q),
        .cmp     (cmp_q),
        .rdata   (rdata)
    );

    assign irq          = status && mask;
    assign dma_rate_48k = !drate;

endmodule

// File: rtl/ssc_stream_counter_chk.sv
module ssc_stream_counter_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         moff,
    input logic         status,
    input logic         inc,
    input logic         clr,
    input logic         ld,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp
);

    p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr && !ld) |=> $stable(cnt));

    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt == $past(cnt) + W'(1)));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (cnt == {W{1'b1}})) |=> (cnt == '0));

    p_set_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> (cnt == $past(cmp)));

    p_match_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (moff && !status) |=> !status);

    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    p_clear_no_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !status) |=> !status);

endmodule

bind ssc_stream_counter ssc_stream_counter_chk #(.W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .moff   (moff),
    .status (status),
    .inc    (inc),
    .clr    (clr_pulse),
    .ld     (wr_cnt),
    .cnt    (cnt_q),
    .cmp    (cmp_q)
);

// File: tb/ssc_stream_counter_test.sv
module ssc_stream_counter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        tick_32k = 1'b0;
    logic        tick_48k = 1'b0;
    logic        irq;
    logic        dma_rate_48k;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ssc_stream_counter uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .tick_32k     (tick_32k),
        .tick_48k     (tick_48k),
        .irq          (irq),
        .dma_rate_48k (dma_rate_48k)
    );

    // behavioural reference state
    logic [31:0] m_cnt = 0, m_cmp = 0, m_vol = 0;
    bit m_run = 0, m_srate = 0, m_mask = 0, m_stat = 0, m_moff = 0, m_drate = 0;

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: m_read = {25'd0, m_drate, 1'b0, m_moff, m_stat, m_mask, m_srate, m_run};
            2'd1: m_read = m_vol;
            2'd2: m_read = m_cnt;
            default: m_read = m_cmp;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit wc, step, hit;
        logic [31:0] nxt;
        wc = wr_en && addr == 2'd0;
        if (!rst_n) begin
            m_cnt = 0; m_cmp = 0; m_vol = 0;
            m_run = 0; m_srate = 0; m_mask = 0; m_stat = 0; m_moff = 0; m_drate = 0;
        end else begin
            step = m_run && (m_srate ? tick_48k : tick_32k);
            hit = 0;
            nxt = m_cnt + 1;
            if (wc && wdata[5]) m_cnt = 0;
            else if (wr_en && addr == 2'd2) m_cnt = wdata;
            else if (step) begin
                hit = (nxt == m_cmp);
                m_cnt = nxt;
            end
            if (hit && !m_moff) m_stat = 1;
            else if (wc && wdata[3]) m_stat = 0;
            if (wc) begin
                m_run = wdata[0]; m_srate = wdata[1]; m_mask = wdata[2];
                m_moff = wdata[4]; m_drate = wdata[6];
            end
            if (wr_en && addr == 2'd1) m_vol = wdata;
            if (wr_en && addr == 2'd3) m_cmp = wdata;
        end
        #5;
        check(rdata, m_read(addr), addr == 2'd0 ? "R7 model ctrl" :
                                   addr == 2'd2 ? "R2 model counter" : "R11 model reg");
        check({31'd0, irq}, {31'd0, m_stat && m_mask}, "R8 model irq");
        check({31'd0, dma_rate_48k}, {31'd0, !m_drate}, "R10 model dma rate");
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit t48 = 0);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d; tick_32k = 0; tick_48k = t48;
    endtask

    task automatic ticks(input int n32, input int n48);
        for (int i = 0; i < ((n32 > n48) ? n32 : n48); i++) begin
            @(negedge clk);
            wr_en = 0; tick_32k = (i < n32); tick_48k = (i < n48);
        end
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = 0; tick_32k = 0; tick_48k = 0; addr = a;
        #2;
        check(rdata, exp, tag);
    endtask

    task automatic pin_chk(input logic act, input logic exp, input string tag);
        #1;
        check({31'd0, act}, {31'd0, exp}, tag);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_chk(2'd0, 32'h0, "R1 ctrl reset");
        rd_chk(2'd1, 32'h0, "R1 vol reset");
        rd_chk(2'd2, 32'h0, "R1 cnt reset");
        rd_chk(2'd3, 32'h0, "R1 cmp reset");
        pin_chk(irq, 1'b0, "R1 irq reset");
        pin_chk(dma_rate_48k, 1'b1, "R1 dma rate reset");
        // R2/R3 32k selected, 48k ignored
        wr(2'd0, 32'h1);
        ticks(3, 2);
        rd_chk(2'd2, 32'd3, "R3 32k selected");
        wr(2'd0, 32'h3);
        ticks(2, 4);
        rd_chk(2'd2, 32'd7, "R3 48k selected");
        // R2 stopped holds
        wr(2'd0, 32'h2);
        ticks(3, 3);
        rd_chk(2'd2, 32'd7, "R2 stopped holds");
        // R5/R8 match sets status, irq
        wr(2'd3, 32'd10);
        wr(2'd0, 32'h7);
        ticks(0, 3);
        rd_chk(2'd0, 32'h0F, "R5 status set on match");
        pin_chk(irq, 1'b1, "R8 irq asserted");
        ticks(0, 2);
        rd_chk(2'd2, 32'd12, "R2 counts past match");
        rd_chk(2'd0, 32'h0F, "R5 status sticky");
        // R7/R8 write 0 keeps, mask gates
        wr(2'd0, 32'h3);
        rd_chk(2'd0, 32'h0B, "R7 write 0 keeps status");
        pin_chk(irq, 1'b0, "R8 mask off");
        wr(2'd0, 32'h0F);
        rd_chk(2'd0, 32'h07, "R7 write 1 clears");
        pin_chk(irq, 1'b0, "R8 no status");
        // R6 match disabled
        wr(2'd2, 32'd20);
        wr(2'd3, 32'd22);
        wr(2'd0, 32'h17);
        ticks(0, 2);
        rd_chk(2'd2, 32'd22, "R6 counter at compare");
        rd_chk(2'd0, 32'h17, "R6 status untouched");
        // R9 clear beats tick, no status with cmp 0
        wr(2'd3, 32'd0);
        wr(2'd0, 32'h27, 1'b1);
        rd_chk(2'd2, 32'd0, "R9 clear zeroes");
        rd_chk(2'd0, 32'h07, "R9 bit reads 0, no status");
        // R4 wrap with match at zero
        wr(2'd2, 32'hFFFF_FFFE);
        ticks(0, 1);
        rd_chk(2'd2, 32'hFFFF_FFFF, "R2 near wrap");
        ticks(0, 1);
        rd_chk(2'd2, 32'd0, "R4 wrapped");
        rd_chk(2'd0, 32'h0F, "R5 match at wrap");
        // R7 set beats clear
        wr(2'd0, 32'h0F);
        rd_chk(2'd0, 32'h07, "R7 cleared");
        wr(2'd2, 32'd4);
        wr(2'd3, 32'd5);
        wr(2'd0, 32'h0F, 1'b1);
        rd_chk(2'd2, 32'd5, "R2 tick during ctrl write");
        rd_chk(2'd0, 32'h0F, "R7 set wins over clear");
        // R11 load beats tick, volume storage
        wr(2'd2, 32'd100, 1'b1);
        rd_chk(2'd2, 32'd100, "R11 load beats tick");
        wr(2'd1, 32'hA5A5_5A5A);
        rd_chk(2'd1, 32'hA5A5_5A5A, "R11 volume");
        // R10/R12 upper bits, dma rate
        wr(2'd0, 32'hFFFF_FFC1);
        rd_chk(2'd0, 32'h49, "R12 upper bits zero");
        pin_chk(dma_rate_48k, 1'b0, "R10 dma 32k");
        wr(2'd0, 32'h1);
        rd_chk(2'd0, 32'h09, "R10 ctrl back");
        pin_chk(dma_rate_48k, 1'b1, "R10 dma 48k");
        ticks(4, 0);
        rd_chk(2'd2, 32'd104, "R3 32k again");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule